// File: doc/BRIEF.md
# Inline ECC Address Translator

This block sits between a system bus and an SDRAM controller in a memory system whose check bytes share the same devices as the data. The system sees a gap-free byte address space. Each 256-byte block of system data occupies a 288-byte physical block. The first 256 bytes of that physical block hold the data. The 32 bytes after them hold one check byte for each 8-byte data word. For every accepted request, the block gives the physical data address and the physical address of the check byte that covers that word.

The block also compares the system address against a small set of programmable protected windows. Only an access inside an enabled window has its check byte used. For that access, the block folds the decoder's correctable and uncorrectable indications into the bus response. It counts corrected errors and captures the address of the first uncorrectable one. Two enabled windows that overlap are a configuration error, and every access is then treated as unprotected.

The control path is a four-state machine:
- **IDLE**: the block is ready for a request. `req_valid` moves it to **ISSUE**.
- **ISSUE**: a one-cycle command pulse goes to the memory side. The block always moves on to **WAIT**.
- **WAIT**: the block holds until `mem_done`, which moves it to **RESP**.
- **RESP**: a one-cycle response goes to the requester. The block always returns to **IDLE**.

Top module: `ecc_inline_xlate`

## Requirements
- R1: For system address A, the physical data address is (A >> 8) * 288 + (A & 0xFF). It is presented on `mem_data_addr` in the cycle where `mem_cmd_valid` is 1.
- R2: The check-byte address is (A >> 8) * 288 + 256 + ((A & 0xFF) >> 3). It is presented on `mem_ecc_addr` in the same cycle.
- R3: R1 and R2 apply to every address, whether or not it is protected, up to A = 0xFFFFFFFF.
- R4: `mem_ecc_en` is 1 during the command if and only if A lies inside an enabled window. A window k is enabled when bit k of `win_en` is 1. Its start is field k of `win_lo` (bits 32k+31 to 32k) and its end is field k of `win_hi`. Both bounds are inclusive.
- R5: A window whose enable bit is 0 has no effect on protection. It also takes no part in the overlap check.
- R6: If any two enabled windows share at least one address, `cfg_error` is 1 and every access is unprotected.
- R7: A protected access that completes with `dec_corr`=1 and `dec_uncorr`=0 increments `corr_count` and gives `resp_error`=0.
- R8: `corr_count` saturates at its all-ones value.
- R9: A protected access that completes with `dec_uncorr`=1 gives `resp_error`=1. It does not increment `corr_count`.
- R10: The first uncorrectable error after reset sets `uerr_valid` and captures its system address in `uerr_addr`. Later uncorrectable errors leave both unchanged.
- R11: For an unprotected access, the decoder indications are ignored. The response carries no error, the count is unchanged and nothing is captured.
- R12: A request is taken only when `req_ready`=1, which holds only in IDLE. `mem_cmd_valid` pulses for one cycle, in the cycle after the request is taken. `resp_valid` pulses for one cycle, in the cycle after `mem_done` is seen in WAIT.
- R13: After reset, `req_ready`=1, `mem_cmd_valid`=0, `resp_valid`=0, `corr_count`=0 and `uerr_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | AW | System byte address |
| req_ready | output | 1 | Block is idle and takes a request |
| win_lo | input | NR*AW | Window start addresses, one field per window |
| win_hi | input | NR*AW | Window end addresses, inclusive |
| win_en | input | NR | Window enable bits |
| cfg_error | output | 1 | Two enabled windows overlap |
| mem_cmd_valid | output | 1 | Command pulse to the memory side |
| mem_data_addr | output | AW+1 | Physical data address |
| mem_ecc_addr | output | AW+1 | Physical check-byte address |
| mem_ecc_en | output | 1 | Access is protected |
| mem_done | input | 1 | Memory side has completed the access |
| dec_corr | input | 1 | Decoder corrected a single-bit error |
| dec_uncorr | input | 1 | Decoder found an uncorrectable error |
| resp_valid | output | 1 | Response pulse to the requester |
| resp_error | output | 1 | Response ends in an error |
| corr_count | output | CNT_W | Saturating count of corrected errors |
| uerr_valid | output | 1 | An uncorrectable error has been captured |
| uerr_addr | output | AW | System address of the first uncorrectable error |

## Verification
The hardest situation to bring about from the ports is a saturated correction counter that must then hold. Reaching it takes a long run of completed protected accesses, each reporting a correctable error. The bench builds the design with a 3-bit counter, so eight protected accesses with correctable errors are enough to pass the all-ones value. A second hard case is the overlap error, which only appears after a legal configuration has been changed at run time. The bench widens one window across another and then checks that an access that was protected before is now unprotected and that its decoder error is ignored.

// File: rtl/ecc_xlate_pkg.sv
package ecc_xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } xl_state_e;

    typedef struct packed {
        logic corr;
        logic uncorr;
    } dec_stat_t;

endpackage

// File: rtl/eix_addr_map.sv
module eix_addr_map #(
    parameter int AW       = 32,
    parameter int BLK_LOG2 = 8
) (
    input  logic [AW-1:0] sys_addr,
    output logic [AW:0]   data_addr,
    output logic [AW:0]   ecc_addr
);
    localparam int PAW    = AW + 1;
    localparam int ECC_SH = BLK_LOG2 - 3;
    localparam int BLK_B  = 1 << BLK_LOG2;

    logic [PAW-1:0] blk_w;
    logic [PAW-1:0] base;

    // Block index times 9/8 of the block size, formed from two shifts.
    assign blk_w     = PAW'(sys_addr[AW-1:BLK_LOG2]);
    assign base      = (blk_w << BLK_LOG2) + (blk_w << ECC_SH);
    assign data_addr = base + PAW'(sys_addr[BLK_LOG2-1:0]);
    assign ecc_addr  = base + PAW'(BLK_B) + PAW'(sys_addr[BLK_LOG2-1:3]);
endmodule

// File: rtl/eix_range_chk.sv
module eix_range_chk #(
    parameter int AW = 32,
    parameter int NR = 3
) (
    input  logic [AW-1:0]    addr,
    input  logic [NR*AW-1:0] lo,
    input  logic [NR*AW-1:0] hi,
    input  logic [NR-1:0]    en,
    output logic             hit,
    output logic             overlap
);
    logic [NR-1:0]    hit_v;
    logic [NR*NR-1:0] ovl_v;

    genvar i, j;
    generate
        for (i = 0; i < NR; i++) begin : g_win
            assign hit_v[i] = en[i]
                && (addr >= lo[i*AW +: AW])
                && (addr <= hi[i*AW +: AW]);
            for (j = 0; j < NR; j++) begin : g_pair
                if (j > i) begin : g_cmp
                    assign ovl_v[i*NR+j] = en[i] && en[j]
                        && (lo[i*AW +: AW] <= hi[j*AW +: AW])
                        && (lo[j*AW +: AW] <= hi[i*AW +: AW]);
                end else begin : g_none
                    assign ovl_v[i*NR+j] = 1'b0;
                end
            end
        end
    endgenerate

    assign overlap = |ovl_v;
    assign hit     = (|hit_v) && !overlap;
endmodule

// File: rtl/eix_err_track.sv
module eix_err_track #(
    parameter int AW    = 32,
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd,
    input  logic                      prot,
    input  ecc_xlate_pkg::dec_stat_t  stat,
    input  logic [AW-1:0]             addr,
    output logic [CNT_W-1:0]          count,
    output logic                      uerr_valid,
    output logic [AW-1:0]             uerr_addr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic corr_ev;
    logic uerr_ev;

    assign uerr_ev = upd && prot && stat.uncorr;
    assign corr_ev = upd && prot && stat.corr && !stat.uncorr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (corr_ev && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uerr_valid <= 1'b0;
            uerr_addr  <= '0;
        end else if (uerr_ev && !uerr_valid) begin
            uerr_valid <= 1'b1;
            uerr_addr  <= addr;
        end
    end
endmodule

// File: rtl/ecc_inline_xlate.sv
module ecc_inline_xlate #(
    parameter int AW       = 32,
    parameter int NR       = 3,
    parameter int BLK_LOG2 = 8,
    parameter int CNT_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [AW-1:0]      req_addr,
    output logic               req_ready,
    input  logic [NR*AW-1:0]   win_lo,
    input  logic [NR*AW-1:0]   win_hi,
    input  logic [NR-1:0]      win_en,
    output logic               cfg_error,
    output logic               mem_cmd_valid,
    output logic [AW:0]        mem_data_addr,
    output logic [AW:0]        mem_ecc_addr,
    output logic               mem_ecc_en,
    input  logic               mem_done,
    input  logic               dec_corr,
    input  logic               dec_uncorr,
    output logic               resp_valid,
    output logic               resp_error,
    output logic [CNT_W-1:0]   corr_count,
    output logic               uerr_valid,
    output logic [AW-1:0]      uerr_addr
);
    import ecc_xlate_pkg::*;

    xl_state_e state_q, state_d;

    logic [AW-1:0] addr_q;
    logic          prot_q;
    logic          err_q;
    logic          win_hit;
    logic          take;
    logic          done_ev;
    dec_stat_t     stat;

    assign stat.corr   = dec_corr;
    assign stat.uncorr = dec_uncorr;

    eix_range_chk #(.AW(AW), .NR(NR)) u_range (
        .addr    (req_addr),
        .lo      (win_lo),
        .hi      (win_hi),
        .en      (win_en),
        .hit     (win_hit),
        .overlap (cfg_error)
    );

    eix_addr_map #(.AW(AW), .BLK_LOG2(BLK_LOG2)) u_map (
        .sys_addr  (addr_q),
        .data_addr (mem_data_addr),
        .ecc_addr  (mem_ecc_addr)
    );

    eix_err_track #(.AW(AW), .CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (done_ev),
        .prot       (prot_q),
        .stat       (stat),
        .addr       (addr_q),
        .count      (corr_count),
        .uerr_valid (uerr_valid),
        .uerr_addr  (uerr_addr)
    );

    assign take    = (state_q == ST_IDLE) && req_valid;
    assign done_ev = (state_q == ST_WAIT) && mem_done;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (mem_done) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Request and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            prot_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (take) begin
                addr_q <= req_addr;
                prot_q <= win_hit;
            end
            if (done_ev) err_q <= prot_q && dec_uncorr;
        end
    end

    // Outputs by state
    always_comb begin
        req_ready     = 1'b0;
        mem_cmd_valid = 1'b0;
        mem_ecc_en    = 1'b0;
        resp_valid    = 1'b0;
        resp_error    = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: begin
                mem_cmd_valid = 1'b1;
                mem_ecc_en    = prot_q;
            end
            ST_WAIT:  mem_ecc_en = prot_q;
            ST_RESP:  begin
                resp_valid = 1'b1;
                resp_error = err_q;
            end
            default:  req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/eix_chk.sv
module eix_chk #(
    parameter int AW       = 32,
    parameter int BLK_LOG2 = 8,
    parameter int CNT_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_cmd_valid,
    input logic [AW:0]      mem_data_addr,
    input logic [AW:0]      mem_ecc_addr,
    input logic             resp_valid,
    input logic             resp_error,
    input logic [CNT_W-1:0] corr_count,
    input logic             uerr_valid,
    input logic [AW-1:0]    uerr_addr
);
    localparam logic [AW:0] SPAN = (AW+1)'((1 << BLK_LOG2) + (1 << (BLK_LOG2 - 3)));

    // R2
    ecc_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> (mem_ecc_addr > mem_data_addr)
                          && ((mem_ecc_addr - mem_data_addr) <= SPAN));

    // R12
    cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |=> !mem_cmd_valid);

    // R12
    resp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R12
    cmd_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> !req_ready);

    // R9
    err_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_error |-> resp_valid);

    // R8
    count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(corr_count) |-> (corr_count == $past(corr_count) + 1'b1));

    // R10
    uerr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uerr_valid |=> uerr_valid && $stable(uerr_addr));
endmodule

bind ecc_inline_xlate eix_chk #(.AW(AW), .BLK_LOG2(BLK_LOG2), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_data_addr (mem_data_addr),
    .mem_ecc_addr  (mem_ecc_addr),
    .resp_valid    (resp_valid),
    .resp_error    (resp_error),
    .corr_count    (corr_count),
    .uerr_valid    (uerr_valid),
    .uerr_addr     (uerr_addr)
);

// File: tb/ecc_inline_xlate_tb.sv
module ecc_inline_xlate_tb;
    localparam int AW = 32;
    localparam int NR = 3;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready;
    logic [NR*AW-1:0] win_lo = '0;
    logic [NR*AW-1:0] win_hi = '0;
    logic [NR-1:0] win_en = '0;
    logic cfg_error, mem_cmd_valid, mem_ecc_en;
    logic [AW:0] mem_data_addr, mem_ecc_addr;
    logic mem_done = 1'b0, dec_corr = 1'b0, dec_uncorr = 1'b0;
    logic resp_valid, resp_error;
    logic [CW-1:0] corr_count;
    logic uerr_valid;
    logic [AW-1:0] uerr_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    ecc_inline_xlate #(.AW(AW), .NR(NR), .BLK_LOG2(8), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .win_lo(win_lo), .win_hi(win_hi), .win_en(win_en),
        .cfg_error(cfg_error), .mem_cmd_valid(mem_cmd_valid),
        .mem_data_addr(mem_data_addr), .mem_ecc_addr(mem_ecc_addr),
        .mem_ecc_en(mem_ecc_en), .mem_done(mem_done), .dec_corr(dec_corr),
        .dec_uncorr(dec_uncorr), .resp_valid(resp_valid), .resp_error(resp_error),
        .corr_count(corr_count), .uerr_valid(uerr_valid), .uerr_addr(uerr_addr)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic longint exp_data(input longint a);
        return (a >> 8) * 288 + (a & 255);
    endfunction

    function automatic longint exp_ecc(input longint a);
        return (a >> 8) * 288 + 256 + ((a & 255) >> 3);
    endfunction

    task automatic set_win(input int k, input logic [AW-1:0] lo, input logic [AW-1:0] hi, input bit en);
        win_lo[k*AW +: AW] = lo;
        win_hi[k*AW +: AW] = hi;
        win_en[k] = en;
    endtask

    // One complete access; dly = idle cycles in WAIT before mem_done.
    task automatic txn(input logic [AW-1:0] a, input bit corr, input bit unc,
                       input int dly, input bit exp_prot, input bit exp_err, input string req);
        longint ea;
        ea = longint'(a);
        @(negedge clk);
        check(req_ready == 1'b1, "R12 ready in idle", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_cmd_valid == 1'b1 && req_ready == 1'b0, "R12 command pulse", mem_cmd_valid, 1);
        check(longint'(mem_data_addr) == exp_data(ea), {req, " R1 data addr"}, longint'(mem_data_addr), exp_data(ea));
        check(longint'(mem_ecc_addr) == exp_ecc(ea), {req, " R2 ecc addr"}, longint'(mem_ecc_addr), exp_ecc(ea));
        check(mem_ecc_en == exp_prot, {req, " R4 protect"}, mem_ecc_en, exp_prot);
        @(posedge clk);
        @(negedge clk);
        check(mem_cmd_valid == 1'b0, "R12 command single cycle", mem_cmd_valid, 0);
        for (int i = 0; i < dly; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(resp_valid == 1'b0, "R12 no response before done", resp_valid, 0);
        end
        mem_done = 1'b1;
        dec_corr = corr;
        dec_uncorr = unc;
        @(posedge clk);
        @(negedge clk);
        mem_done = 1'b0;
        dec_corr = 1'b0;
        dec_uncorr = 1'b0;
        check(resp_valid == 1'b1, "R12 response after done", resp_valid, 1);
        check(resp_error == exp_err, {req, " response error"}, resp_error, exp_err);
        @(posedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1 && mem_cmd_valid == 0 && resp_valid == 0, "R13 idle outputs",
              {req_ready, mem_cmd_valid, resp_valid}, 3'b100);
        check(corr_count == 0 && uerr_valid == 0, "R13 status clear", {corr_count, uerr_valid}, 0);
    endtask

    task automatic t_translate();
        txn(32'h0000_0000, 0, 0, 0, 0, 0, "R3 zero");
        txn(32'h0000_00FF, 0, 0, 0, 0, 0, "R3 block end");
        txn(32'h0000_0100, 0, 0, 1, 0, 0, "R3 second block");
        txn(32'h0000_1234, 0, 0, 0, 1, 0, "R1 protected");
        txn(32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R3 top address");
    endtask

    task automatic t_bounds();
        txn(32'h0000_0FFF, 0, 0, 0, 0, 0, "R4 below start");
        txn(32'h0000_1000, 0, 0, 0, 1, 0, "R4 at start");
        txn(32'h0000_1FFF, 0, 0, 0, 1, 0, "R4 at end");
        txn(32'h0000_2000, 0, 0, 0, 0, 0, "R4 above end");
        txn(32'h0000_80FF, 0, 0, 0, 1, 0, "R4 second window");
        txn(32'h0000_5000, 0, 0, 0, 0, 0, "R5 disabled window");
        @(negedge clk);
        check(cfg_error == 0, "R5 disabled window no overlap", cfg_error, 0);
    endtask

    task automatic t_correct();
        txn(32'h0000_1008, 1, 0, 2, 1, 0, "R7 corrected");
        @(negedge clk);
        check(corr_count == 1, "R7 count", corr_count, 1);
        for (int k = 0; k < 8; k++) txn(32'h0000_1010, 1, 0, 0, 1, 0, "R8 corrected");
        @(negedge clk);
        check(corr_count == 7, "R8 saturated", corr_count, 7);
    endtask

    task automatic t_unprot_err();
        txn(32'h0000_3000, 1, 1, 0, 0, 0, "R11 unprotected");
        @(negedge clk);
        check(uerr_valid == 0, "R11 no capture", uerr_valid, 0);
    endtask

    task automatic t_uncorr();
        txn(32'h0000_1040, 1, 1, 0, 1, 1, "R9 uncorrectable");
        @(negedge clk);
        check(uerr_valid == 1 && uerr_addr == 32'h1040, "R10 first capture", uerr_addr, 32'h1040);
        check(corr_count == 7, "R9 count unchanged", corr_count, 7);
        txn(32'h0000_8020, 0, 1, 0, 1, 1, "R9 second uncorrectable");
        @(negedge clk);
        check(uerr_addr == 32'h1040, "R10 capture kept", uerr_addr, 32'h1040);
    endtask

    task automatic t_overlap();
        @(negedge clk);
        set_win(1, 32'h0000_1800, 32'h0000_9000, 1);
        #1;
        check(cfg_error == 1, "R6 overlap flag", cfg_error, 1);
        txn(32'h0000_1010, 0, 1, 0, 0, 0, "R6 overlap unprotected");
    endtask

    initial begin
        set_win(0, 32'h0000_1000, 32'h0000_1FFF, 1);
        set_win(1, 32'h0000_8000, 32'h0000_80FF, 1);
        set_win(2, 32'h0000_0000, 32'hFFFF_FFFF, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_translate();
        t_bounds();
        t_correct();
        t_unprot_err();
        t_uncorr();
        t_overlap();
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule